// File: doc/BRIEF.md
# Multi-Size Address Translation Cache

This block caches virtual-to-physical page translations for a memory management unit. Two pools of fully associative entries are searched in the same cycle. The base pool holds 4 KB translations. A smaller huge pool holds 2 MB and 1 GB translations, and each huge entry records its own size. A lookup carries a virtual address, a write flag and a user flag. One cycle later the block returns exactly one outcome: a hit with the physical address, a permission fault, or a miss. A miss presents the virtual address to the page-table walker.

The requester keeps its access pending until the walker has delivered the translation through the fill port, and then it retries. Software-directed maintenance arrives on the invalidate port. It can remove the translations that cover one page, or it can clear every entry. The block acknowledges each invalidate with a single-cycle pulse.

Top module: `mmu_xlat_cache`

## Requirements
- R1: The base pool holds 64 entries for 4 KB pages. The huge pool is separate, so installing a huge-page translation never displaces a 4 KB translation.
- R2: A lookup presented in cycle N produces `rsp_valid_o` in cycle N+1. `rsp_valid_o` is low in any cycle that does not follow a lookup.
- R3: When no valid entry covers the address, the response is a miss. `miss_valid_o` is high, `miss_vaddr_o` carries the request address, and exactly one of hit, fault and miss is set in each response.
- R4: A fill installs its translation, so a later lookup to any address in that page hits.
- R5: `fill_size_i` encodes the page size as 0 for 4 KB, 1 for 2 MB and 2 for 1 GB. The physical address takes its low 12, 21 or 30 bits from the virtual address and its upper bits from the frame number, where the frame number is the physical address shifted right by 12.
- R6: A covered lookup whose write flag is set while the entry's write permission is clear, or whose user flag is set while the entry's user permission is clear, reports a fault. It does not report a hit or a miss.
- R7: A single-page invalidate removes every entry whose page contains the given 4 KB page number, and leaves all other entries intact.
- R8: `inv_ack_o` is high for exactly the one cycle that follows each cycle in which `inv_valid_i` is high.
- R9: A lookup presented in the same cycle as an invalidate that covers its page reports a miss.
- R10: An invalidate-all clears every entry in both pools in a single cycle.
- R11: A fill goes to the lowest-numbered invalid entry of its pool. When the pool is full, a round-robin pointer picks the victim and advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 39 | Virtual address of the lookup |
| req_write_i | input | 1 | Lookup is a write |
| req_user_i | input | 1 | Lookup is from user mode |
| rsp_valid_o | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit_o | output | 1 | Translation found and permitted |
| rsp_fault_o | output | 1 | Translation found but access not permitted |
| rsp_paddr_o | output | 40 | Physical address, meaningful on hit |
| miss_valid_o | output | 1 | Walk request to the page-table walker |
| miss_vaddr_o | output | 39 | Address to be walked |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 27 | Virtual page number (4 KB units) |
| fill_pfn_i | input | 28 | Physical frame number (4 KB units) |
| fill_size_i | input | 2 | Page size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| fill_write_ok_i | input | 1 | Writes permitted |
| fill_user_ok_i | input | 1 | User access permitted |
| inv_valid_i | input | 1 | Invalidate command |
| inv_all_i | input | 1 | Invalidate every entry |
| inv_vpn_i | input | 27 | 4 KB page number to invalidate |
| inv_ack_o | output | 1 | Invalidate completed |

## Verification
Corrupt entry state becomes visible on the next lookup to the affected page, which is one cycle after that lookup is issued. A stale valid bit shows up as a hit where a miss is expected. A lost entry shows up as an unexpected miss. A wrong size field or a wrong size mask shows up as a wrong physical address or as a miss at a far offset inside a huge page. A round-robin pointer that is off by one moves the eviction to a different page, and the error appears only after the pool has filled, so the bench fills the base pool completely and probes which pages survive.

// File: rtl/mmu_xlat_pkg.sv
package mmu_xlat_pkg;
  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  localparam int unsigned LVL_BITS = 9;
endpackage

// File: rtl/mmu_xlat_pool.sv
module mmu_xlat_pool
  import mmu_xlat_pkg::*;
#(
  parameter int unsigned N     = 64,
  parameter int unsigned VPN_W = 27,
  parameter int unsigned PFN_W = 28,
  parameter bit          HUGE  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PFN_W-1:0] lk_pfn_o,
  output logic             lk_wr_o,
  output logic             lk_usr_o,
  output pg_size_e         lk_size_o,
  input  logic             inv_i,
  input  logic             inv_all_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_wr_i,
  input  logic             fill_usr_i,
  input  pg_size_e         fill_size_i
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     valid_q;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PFN_W-1:0] pfn_q [N];
  logic [N-1:0]     wr_q, usr_q;
  pg_size_e         size_q [N];
  logic [IDX_W-1:0] rr_q, victim;
  logic             any_free;
  logic [N-1:0]     lk_match, inv_match;

  function automatic logic [VPN_W-1:0] span_mask(pg_size_e s);
    logic [VPN_W-1:0] m;
    m = '1;
    if (s == PG_2M) m[LVL_BITS-1:0] = '0;
    else if (s == PG_1G) m[2*LVL_BITS-1:0] = '0;
    return m;
  endfunction

  // size storage only exists in the huge pool
  if (HUGE) begin : g_size
    always_ff @(posedge clk_i) begin
      if (fill_i) size_q[victim] <= fill_size_i;
    end
  end else begin : g_fixed
    for (genvar g = 0; g < N; g++) begin : g_e
      assign size_q[g] = PG_4K;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lk_match[i]  = valid_q[i] && (((vpn_q[i] ^ lk_vpn_i) & span_mask(size_q[i])) == '0);
      inv_match[i] = valid_q[i] &&
                     (inv_all_i || (((vpn_q[i] ^ inv_vpn_i) & span_mask(size_q[i])) == '0));
    end
  end

  // an entry being invalidated this cycle must not hit
  always_comb begin
    lk_hit_o  = 1'b0;
    lk_pfn_o  = '0;
    lk_wr_o   = 1'b0;
    lk_usr_o  = 1'b0;
    lk_size_o = PG_4K;
    for (int i = 0; i < N; i++) begin
      if (!lk_hit_o && lk_match[i] && !(inv_i && inv_match[i])) begin
        lk_hit_o  = 1'b1;
        lk_pfn_o  = pfn_q[i];
        lk_wr_o   = wr_q[i];
        lk_usr_o  = usr_q[i];
        lk_size_o = size_q[i];
      end
    end
  end

  always_comb begin
    any_free = 1'b0;
    victim   = rr_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        victim   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (inv_i && inv_match[i]) valid_q[i] <= 1'b0;
      end
      if (fill_i) begin
        valid_q[victim] <= 1'b1;
        if (!any_free) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      vpn_q[victim] <= fill_vpn_i;
      pfn_q[victim] <= fill_pfn_i;
      wr_q[victim]  <= fill_wr_i;
      usr_q[victim] <= fill_usr_i;
    end
  end
endmodule

// File: rtl/mmu_xlat_cache.sv
module mmu_xlat_cache
  import mmu_xlat_pkg::*;
#(
  parameter int unsigned VA_W   = 39,
  parameter int unsigned PA_W   = 40,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned BASE_N = 64,
  parameter int unsigned HUGE_N = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [VA_W-1:0]       req_vaddr_i,
  input  logic                  req_write_i,
  input  logic                  req_user_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_hit_o,
  output logic                  rsp_fault_o,
  output logic [PA_W-1:0]       rsp_paddr_o,
  output logic                  miss_valid_o,
  output logic [VA_W-1:0]       miss_vaddr_o,
  input  logic                  fill_valid_i,
  input  logic [VA_W-OFF_W-1:0] fill_vpn_i,
  input  logic [PA_W-OFF_W-1:0] fill_pfn_i,
  input  logic [1:0]            fill_size_i,
  input  logic                  fill_write_ok_i,
  input  logic                  fill_user_ok_i,
  input  logic                  inv_valid_i,
  input  logic                  inv_all_i,
  input  logic [VA_W-OFF_W-1:0] inv_vpn_i,
  output logic                  inv_ack_o
);
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PFN_W = PA_W - OFF_W;

  pg_size_e         fsize;
  logic             fill_base, fill_huge;
  logic             b_hit, h_hit, b_wr, h_wr, b_usr, h_usr;
  logic [PFN_W-1:0] b_pfn, h_pfn;
  pg_size_e         b_size, h_size;
  logic             hit, wr_ok, usr_ok, fault;
  logic [PFN_W-1:0] pfn;
  pg_size_e         size;
  logic [PA_W-1:0]  off_mask, paddr;

  assign fsize     = pg_size_e'(fill_size_i);
  assign fill_base = fill_valid_i && (fsize == PG_4K);
  assign fill_huge = fill_valid_i && (fsize != PG_4K);

  mmu_xlat_pool #(.N(BASE_N), .VPN_W(VPN_W), .PFN_W(PFN_W), .HUGE(1'b0)) u_base (
    .clk_i, .rst_ni,
    .lk_vpn_i (req_vaddr_i[VA_W-1:OFF_W]),
    .lk_hit_o (b_hit), .lk_pfn_o (b_pfn), .lk_wr_o (b_wr), .lk_usr_o (b_usr),
    .lk_size_o(b_size),
    .inv_i (inv_valid_i), .inv_all_i, .inv_vpn_i,
    .fill_i (fill_base), .fill_vpn_i, .fill_pfn_i,
    .fill_wr_i (fill_write_ok_i), .fill_usr_i (fill_user_ok_i), .fill_size_i(fsize)
  );

  mmu_xlat_pool #(.N(HUGE_N), .VPN_W(VPN_W), .PFN_W(PFN_W), .HUGE(1'b1)) u_huge (
    .clk_i, .rst_ni,
    .lk_vpn_i (req_vaddr_i[VA_W-1:OFF_W]),
    .lk_hit_o (h_hit), .lk_pfn_o (h_pfn), .lk_wr_o (h_wr), .lk_usr_o (h_usr),
    .lk_size_o(h_size),
    .inv_i (inv_valid_i), .inv_all_i, .inv_vpn_i,
    .fill_i (fill_huge), .fill_vpn_i, .fill_pfn_i,
    .fill_wr_i (fill_write_ok_i), .fill_usr_i (fill_user_ok_i), .fill_size_i(fsize)
  );

  always_comb begin
    hit    = b_hit | h_hit;
    pfn    = b_hit ? b_pfn  : h_pfn;
    wr_ok  = b_hit ? b_wr   : h_wr;
    usr_ok = b_hit ? b_usr  : h_usr;
    size   = b_hit ? b_size : h_size;
    fault  = hit && ((req_write_i && !wr_ok) || (req_user_i && !usr_ok));
    off_mask = '0;
    case (size)
      PG_2M:   off_mask[OFF_W+LVL_BITS-1:0]   = '1;
      PG_1G:   off_mask[OFF_W+2*LVL_BITS-1:0] = '1;
      default: off_mask[OFF_W-1:0]            = '1;
    endcase
    paddr = ({pfn, {OFF_W{1'b0}}} & ~off_mask) | (PA_W'(req_vaddr_i) & off_mask);
  end

  logic            rsp_valid_q, hit_q, fault_q, miss_q, ack_q;
  logic [PA_W-1:0] paddr_q;
  logic [VA_W-1:0] vaddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      hit_q       <= 1'b0;
      fault_q     <= 1'b0;
      miss_q      <= 1'b0;
      ack_q       <= 1'b0;
      paddr_q     <= '0;
      vaddr_q     <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      hit_q       <= req_valid_i && hit && !fault;
      fault_q     <= req_valid_i && fault;
      miss_q      <= req_valid_i && !hit;
      ack_q       <= inv_valid_i;
      if (req_valid_i) begin
        paddr_q <= paddr;
        vaddr_q <= req_vaddr_i;
      end
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_hit_o    = hit_q;
  assign rsp_fault_o  = fault_q;
  assign rsp_paddr_o  = paddr_q;
  assign miss_valid_o = miss_q;
  assign miss_vaddr_o = vaddr_q;
  assign inv_ack_o    = ack_q;
endmodule

// File: rtl/mmu_xlat_cache_chk.sv
module mmu_xlat_cache_chk #(
  parameter int unsigned VA_W  = 39,
  parameter int unsigned OFF_W = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic [VA_W-1:0]       req_vaddr_i,
  input logic                  rsp_valid_o,
  input logic                  rsp_hit_o,
  input logic                  rsp_fault_o,
  input logic                  miss_valid_o,
  input logic [VA_W-1:0]       miss_vaddr_o,
  input logic                  inv_valid_i,
  input logic                  inv_all_i,
  input logic [VA_W-OFF_W-1:0] inv_vpn_i,
  input logic                  inv_ack_o
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);  // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);  // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_fault_o, miss_valid_o}) == 1);  // R3
  AST_MISS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!miss_valid_o || miss_vaddr_o == $past(req_vaddr_i)));  // R3
  AST_ACK_AFTER_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> inv_ack_o);  // R8
  AST_ACK_ONLY_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inv_valid_i |=> !inv_ack_o);  // R8
  AST_SAME_CYCLE_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && inv_valid_i && (inv_all_i || inv_vpn_i == req_vaddr_i[VA_W-1:OFF_W]))
    |=> (miss_valid_o && !rsp_hit_o && !rsp_fault_o));  // R9
endmodule

bind mmu_xlat_cache mmu_xlat_cache_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_mmu_xlat_cache.sv
`timescale 1ns/1ps
module tb_mmu_xlat_cache;
  localparam int VA_W = 39;
  localparam int PA_W = 40;
  localparam int VPN_W = VA_W - 12;
  localparam int PFN_W = PA_W - 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_user = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic rsp_valid, rsp_hit, rsp_fault, miss_valid, inv_ack;
  logic [PA_W-1:0] rsp_paddr;
  logic [VA_W-1:0] miss_vaddr;
  logic fill_valid = 0, fill_wr = 0, fill_usr = 0;
  logic [VPN_W-1:0] fill_vpn = '0, inv_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic [1:0] fill_size = '0;
  logic inv_valid = 0, inv_all = 0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mmu_xlat_cache dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .req_user_i(req_user), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr), .miss_valid_o(miss_valid),
    .miss_vaddr_o(miss_vaddr), .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn),
    .fill_pfn_i(fill_pfn), .fill_size_i(fill_size), .fill_write_ok_i(fill_wr),
    .fill_user_ok_i(fill_usr), .inv_valid_i(inv_valid), .inv_all_i(inv_all),
    .inv_vpn_i(inv_vpn), .inv_ack_o(inv_ack)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [VA_W-1:0] va, input logic wr, input logic usr);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_user = 0;
  endtask

  task automatic fill(input logic [VA_W-1:0] va, input logic [PFN_W-1:0] pfn,
                      input logic [1:0] sz, input logic wr, input logic usr);
    @(negedge clk);
    fill_valid = 1; fill_vpn = va[VA_W-1:12]; fill_pfn = pfn; fill_size = sz;
    fill_wr = wr; fill_usr = usr;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic invalidate(input logic [VA_W-1:0] va, input logic all);
    @(negedge clk);
    inv_valid = 1; inv_all = all; inv_vpn = va[VA_W-1:12];
    @(negedge clk);
    inv_valid = 0; inv_all = 0;
    check(inv_ack == 1'b1, "R8 ack after invalidate", 64'(inv_ack), 64'd1);
    @(negedge clk);
    check(inv_ack == 1'b0, "R8 ack single pulse", 64'(inv_ack), 64'd0);
  endtask

  task automatic expect_hit(input string req, input logic [PA_W-1:0] pa);
    check(rsp_valid && rsp_hit && !rsp_fault && !miss_valid, req,
          64'({rsp_valid, rsp_hit, rsp_fault, miss_valid}), 64'b1100);
    check(rsp_paddr == pa, req, 64'(rsp_paddr), 64'(pa));
  endtask

  task automatic expect_miss(input string req, input logic [VA_W-1:0] va);
    check(rsp_valid && !rsp_hit && !rsp_fault && miss_valid, req,
          64'({rsp_valid, rsp_hit, rsp_fault, miss_valid}), 64'b1001);
    check(miss_vaddr == va, req, 64'(miss_vaddr), 64'(va));
  endtask

  localparam logic [VA_W-1:0] VA_A = 39'h12_3456_7ABC;
  localparam logic [VA_W-1:0] VA_B = 39'h40_2000_0000;  // 2 MB page
  localparam logic [VA_W-1:0] VA_C = 39'h01_8000_0000;  // 1 GB page
  localparam logic [VA_W-1:0] VA_D = 39'h22_0000_5000;
  localparam logic [VA_W-1:0] VA_E = 39'h33_0000_9000;
  localparam logic [PFN_W-1:0] PF_A = 28'h0ABC_DE1;
  localparam logic [PFN_W-1:0] PF_B = 28'h0345_600;
  localparam logic [PFN_W-1:0] PF_C = 28'h0AC0_000;

  task automatic t_reset;
    check(!rsp_valid && !miss_valid && !inv_ack, "R2 reset outputs idle",
          64'({rsp_valid, miss_valid, inv_ack}), 64'd0);
  endtask

  task automatic t_miss_empty;
    lookup(VA_A, 0, 0);
    expect_miss("R3 miss on empty cache", VA_A);
    @(negedge clk);
    check(!rsp_valid, "R2 no response without request", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_fill_hit;
    fill(VA_A, PF_A, 2'd0, 1, 1);
    lookup(VA_A, 1, 1);
    expect_hit("R4 R5 4KB hit after fill", {PF_A, VA_A[11:0]});
    lookup(VA_A + 39'h1000, 0, 0);
    expect_miss("R4 neighbour page misses", VA_A + 39'h1000);
  endtask

  task automatic t_huge;
    logic [VA_W-1:0] vb, vc;
    vb = VA_B | 39'h1F_F123;
    vc = VA_C | 39'h3ABC_DEF0;
    fill(VA_B, PF_B, 2'd1, 1, 1);
    lookup(vb, 0, 0);
    expect_hit("R5 2MB offset passes", {PF_B[PFN_W-1:9], vb[20:0]});
    fill(VA_C, PF_C, 2'd2, 1, 1);
    lookup(vc, 0, 1);
    expect_hit("R5 1GB offset passes", {PF_C[PFN_W-1:18], vc[29:0]});
    lookup(VA_A, 0, 0);
    expect_hit("R1 base entry kept after huge fills", {PF_A, VA_A[11:0]});
  endtask

  task automatic t_perm;
    fill(VA_D, 28'h0000_777, 2'd0, 0, 0);
    lookup(VA_D, 1, 0);
    check(rsp_fault && !rsp_hit && !miss_valid, "R6 write to read-only faults",
          64'({rsp_fault, rsp_hit, miss_valid}), 64'b100);
    lookup(VA_D, 0, 1);
    check(rsp_fault && !rsp_hit && !miss_valid, "R6 user to supervisor page faults",
          64'({rsp_fault, rsp_hit, miss_valid}), 64'b100);
    lookup(VA_D, 0, 0);
    expect_hit("R6 permitted read hits", {28'h0000_777, VA_D[11:0]});
  endtask

  task automatic t_inv_one;
    invalidate(VA_A, 0);
    lookup(VA_A, 0, 0);
    expect_miss("R7 invalidated page misses", VA_A);
    lookup(VA_D, 0, 0);
    expect_hit("R7 other page survives", {28'h0000_777, VA_D[11:0]});
    invalidate(VA_B | 39'h0A_3000, 0);
    lookup(VA_B, 0, 0);
    expect_miss("R7 huge page removed by inner page", VA_B);
  endtask

  task automatic t_same_cycle;
    fill(VA_E, 28'h0000_123, 2'd0, 1, 1);
    @(negedge clk);
    req_valid = 1; req_vaddr = VA_E;
    inv_valid = 1; inv_all = 0; inv_vpn = VA_E[VA_W-1:12];
    @(negedge clk);
    req_valid = 0; inv_valid = 0;
    expect_miss("R9 lookup with same-cycle invalidate misses", VA_E);
    check(inv_ack, "R8 ack with concurrent lookup", 64'(inv_ack), 64'd1);
    lookup(VA_E, 0, 0);
    expect_miss("R9 entry stays removed", VA_E);
  endtask

  task automatic t_inv_all;
    invalidate('0, 1);
    lookup(VA_C, 0, 0);
    expect_miss("R10 huge pool cleared", VA_C);
    lookup(VA_D, 0, 0);
    expect_miss("R10 base pool cleared", VA_D);
  endtask

  function automatic logic [VA_W-1:0] pg(input int k);
    return VA_W'(39'h50_0000_0000 + (longint'(k) << 12));
  endfunction

  task automatic t_repl;
    for (int k = 0; k < 64; k++) fill(pg(k), PFN_W'(k + 16), 2'd0, 1, 1);
    fill(VA_C, PF_C, 2'd2, 1, 1);
    lookup(pg(0), 0, 0);
    expect_hit("R1 R11 full base pool keeps first page", {PFN_W'(16), 12'h000});
    lookup(pg(63), 0, 0);
    expect_hit("R1 sixty-fourth entry present", {PFN_W'(79), 12'h000});
    fill(pg(64), PFN_W'(80), 2'd0, 1, 1);
    lookup(pg(0), 0, 0);
    expect_miss("R11 round robin evicts oldest", pg(0));
    lookup(pg(64), 0, 0);
    expect_hit("R11 new page installed", {PFN_W'(80), 12'h000});
    fill(pg(65), PFN_W'(81), 2'd0, 1, 1);
    lookup(pg(1), 0, 0);
    expect_miss("R11 pointer advanced", pg(1));
    lookup(pg(2), 0, 0);
    expect_hit("R11 next page retained", {PFN_W'(18), 12'h000});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_miss_empty();
    t_fill_hit();
    t_huge();
    t_perm();
    t_inv_one();
    t_same_cycle();
    t_inv_all();
    t_repl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule